// File: doc/BRIEF.md
# Processor Exception Entry and Return Unit

This block sits next to a small 32-bit processor core and owns the control side of exception handling. In every cycle it looks at the pending exception requests and at the instruction the core is executing. It decides whether a handler is entered and, if so, which one. For that cycle it hands the datapath the handler address to load into the program counter and the link value to write into the link register of the new mode. At the next clock edge it commits the new status word, with the new mode and interrupt masks, and the saved copy of the old status.

The unit holds the current status word and one saved-status register for each privileged exception mode. A return-with-status operation loads the program counter from the link value and restores the status word from the saved copy of the current mode. Both take effect as one operation. The core can also write the status word directly, for example to drop into user mode. The software-interrupt number is decoded from the trapping instruction and exposed for the handler. The register file, the memory and the rest of the datapath stay outside.

Top module: `exc_entry_unit`

## Requirements
- R1: An entry loads the program counter with the handler address for the exception kind: reset 0x00, undefined opcode 0x04, software interrupt 0x08, fetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C. Address 0x14 is never produced.
- R2: A valid instruction whose bits 27:24 are 1111 is a software interrupt, whatever its bits 31:28 hold. `trap_num_o` carries its bits 23:0, which is the instruction word with its upper 8 bits cleared.
- R3: When several requests are eligible in one cycle, only one is taken. The order of precedence is reset, data abort, fast interrupt, normal interrupt, fetch abort, undefined opcode, software interrupt. `kind_o` encodes them as 1, 2, 3, 4, 5, 6, 7 in that same order, and 0 means nothing is taken.
- R4: Normal and fast interrupt requests are level-sensitive. A normal interrupt is taken only while status bit 7 is 0, and a fast interrupt only while status bit 6 is 0. Every kind except reset is taken only while `instr_valid_i` marks an instruction boundary; reset is taken at any time.
- R5: On entry, the old status word is copied into the saved-status register of the target mode. `spsr_o` always shows the saved-status register of the current mode, or zero in a mode that has none.
- R6: On entry, status bits 4:0 become the mode code of the target mode: 0x13 supervisor (reset and software interrupt), 0x17 abort (both aborts), 0x1B undefined, 0x12 interrupt, 0x11 fast interrupt. User mode is 0x10. Bit 7 is set on every entry. Bit 6 is set on reset and fast-interrupt entry and kept on all others, and the remaining bits are kept.
- R7: On entry, the link value is the instruction address with bits 1:0 cleared, plus 8 for a data abort and plus 4 for every other kind. A reset entry writes no link register.
- R8: A return request at an instruction boundary, in a mode that has a saved-status register, loads the program counter with `ret_link_i` with bits 1:0 cleared. In the same operation the status word is restored from that saved copy. An entry in the same cycle takes precedence over the return.
- R9: A return request in user mode is ignored: no program counter load, and the status word is unchanged.
- R10: After the asynchronous reset, the status word is 0x000000D3 and every saved-status register is zero.
- R11: When nothing is taken and no return happens, the program counter is not loaded. The status word then changes only through the core write port, and that port is ignored in any cycle with an entry or a return.
- R12: The handler address, link value and software-interrupt number are valid in the cycle of the request. The status word, mode, masks and saved copy are all committed together at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| instr_valid_i | input | 1 | An instruction is at its boundary this cycle |
| instr_word_i | input | 32 | Instruction word being executed |
| instr_addr_i | input | 32 | Address of that instruction |
| rst_req_i | input | 1 | Reset exception request |
| undef_req_i | input | 1 | Undefined opcode flagged by the decoder |
| pabt_req_i | input | 1 | Fetch abort on this instruction |
| dabt_req_i | input | 1 | Data access abort |
| irq_req_i | input | 1 | Normal interrupt request, level |
| fiq_req_i | input | 1 | Fast interrupt request, level |
| ret_req_i | input | 1 | Return-with-status operation |
| ret_link_i | input | 32 | Link value for the return |
| core_we_i | input | 1 | Core writes the status word |
| core_wd_i | input | 32 | Status value written by the core |
| status_o | output | 32 | Current status word |
| spsr_o | output | 32 | Saved status of the current mode |
| take_o | output | 1 | An exception is entered this cycle |
| kind_o | output | 3 | Kind of the exception entered |
| pc_load_o | output | 1 | Program counter load strobe |
| pc_value_o | output | 32 | Value for the program counter |
| link_we_o | output | 1 | Link register write strobe |
| link_value_o | output | 32 | Value for the link register |
| trap_hit_o | output | 1 | Instruction is a software interrupt |
| trap_num_o | output | 24 | Software-interrupt number |

## Verification
The bench walks a table of priority collisions and mask states. A wrong ranking would show up as the wrong kind or handler address, for example a normal interrupt winning over a fast one, or a software interrupt winning over a pending interrupt. Masked interrupts, and interrupts raised off an instruction boundary, must leave the status word as it was. A design that ignored the mask bits would vector anyway. Further tests cover an unaligned instruction address and an unaligned return link, where a design that did not clear bits 1:0 would hand back an odd address. They also cover a return in user mode, which must be ignored, and a return colliding with an interrupt, where restoring status first would lose the interrupt entry. A core write that collides with an entry must lose, or the new mode would be overwritten.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int WORD_W  = 32;
  localparam int NUM_W   = 24;
  localparam int MODE_W  = 5;
  localparam int VEC_W   = 8;
  localparam int NREQ    = 7;
  localparam int NBANK   = 5;
  localparam int BANK_W  = $clog2(NBANK);
  localparam int IMASK_B = 7;
  localparam int FMASK_B = 6;

  // kind codes follow the priority order (1 = highest)
  typedef enum logic [2:0] {
    EK_NONE  = 3'd0,
    EK_RESET = 3'd1,
    EK_DABT  = 3'd2,
    EK_FIQ   = 3'd3,
    EK_IRQ   = 3'd4,
    EK_PABT  = 3'd5,
    EK_UNDEF = 3'd6,
    EK_TRAP  = 3'd7
  } exc_kind_e;

  localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;

  function automatic logic [VEC_W-1:0] vec_of(exc_kind_e k);
    case (k)
      EK_RESET: vec_of = 8'h00;
      EK_UNDEF: vec_of = 8'h04;
      EK_TRAP:  vec_of = 8'h08;
      EK_PABT:  vec_of = 8'h0C;
      EK_DABT:  vec_of = 8'h10;
      EK_IRQ:   vec_of = 8'h18;
      EK_FIQ:   vec_of = 8'h1C;
      default:  vec_of = 8'h00;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] mode_of(exc_kind_e k);
    case (k)
      EK_RESET, EK_TRAP: mode_of = MODE_SVC;
      EK_PABT, EK_DABT:  mode_of = MODE_ABT;
      EK_UNDEF:          mode_of = MODE_UND;
      EK_IRQ:            mode_of = MODE_IRQ;
      EK_FIQ:            mode_of = MODE_FIQ;
      default:           mode_of = MODE_USR;
    endcase
  endfunction

  function automatic logic [3:0] link_off(exc_kind_e k);
    link_off = (k == EK_DABT) ? 4'd8 : 4'd4;
  endfunction

  function automatic logic has_bank(logic [MODE_W-1:0] m);
    has_bank = (m == MODE_SVC) || (m == MODE_ABT) || (m == MODE_UND) ||
               (m == MODE_IRQ) || (m == MODE_FIQ);
  endfunction

  function automatic logic [BANK_W-1:0] bank_idx(logic [MODE_W-1:0] m);
    case (m)
      MODE_ABT: bank_idx = BANK_W'(1);
      MODE_UND: bank_idx = BANK_W'(2);
      MODE_IRQ: bank_idx = BANK_W'(3);
      MODE_FIQ: bank_idx = BANK_W'(4);
      default:  bank_idx = BANK_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/exc_trap_decode.sv
module exc_trap_decode
  import exc_pkg::*;
(
  input  logic             valid_i,
  input  logic [27:0]      word_i,
  output logic             hit_o,
  output logic [NUM_W-1:0] num_o
);

  localparam logic [3:0] TRAP_OPC = 4'b1111;

  always_comb begin
    hit_o = valid_i && (word_i[27:24] == TRAP_OPC);
    num_o = word_i[NUM_W-1:0];
  end

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic      boundary_i,
  input  logic      imask_i,
  input  logic      fmask_i,
  input  logic      rst_req_i,
  input  logic      dabt_req_i,
  input  logic      fiq_req_i,
  input  logic      irq_req_i,
  input  logic      pabt_req_i,
  input  logic      undef_req_i,
  input  logic      trap_hit_i,
  output exc_kind_e kind_o
);

  logic [NREQ-1:0] raw;
  logic [NREQ-1:0] elig;
  logic [NREQ-1:0] need_bnd;

  always_comb begin
    raw      = {trap_hit_i, undef_req_i, pabt_req_i,
                irq_req_i & ~imask_i, fiq_req_i & ~fmask_i,
                dabt_req_i, rst_req_i};
    need_bnd = {{(NREQ-1){1'b1}}, 1'b0};
  end

  for (genvar g = 0; g < NREQ; g++) begin : g_gate
    assign elig[g] = raw[g] & (boundary_i | ~need_bnd[g]);
  end

  always_comb begin
    kind_o = EK_NONE;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (elig[i]) kind_o = exc_kind_e'(3'(i + 1));
    end
  end

endmodule

// File: rtl/exc_status_bank.sv
module exc_status_bank
  import exc_pkg::*;
#(
  parameter logic [WORD_W-1:0] STATUS_RST = 32'h0000_00D3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter_i,
  input  exc_kind_e         kind_i,
  input  logic              ret_req_i,
  input  logic              core_we_i,
  input  logic [WORD_W-1:0] core_wd_i,
  output logic [WORD_W-1:0] status_o,
  output logic [WORD_W-1:0] spsr_o,
  output logic              ret_ok_o
);

  logic [WORD_W-1:0] stat_q, stat_d;
  logic              stat_en;
  logic [WORD_W-1:0] bank_q [NBANK];
  logic [NBANK-1:0]  bank_we;
  logic              cur_bank;
  logic [BANK_W-1:0] cur_idx;
  logic [BANK_W-1:0] tgt_idx;

  always_comb begin
    cur_bank = has_bank(stat_q[MODE_W-1:0]);
    cur_idx  = bank_idx(stat_q[MODE_W-1:0]);
    tgt_idx  = bank_idx(mode_of(kind_i));
    spsr_o   = cur_bank ? bank_q[cur_idx] : '0;
    ret_ok_o = ret_req_i && cur_bank && !enter_i;
  end

  // next-state for the status word
  always_comb begin
    stat_d  = stat_q;
    stat_en = 1'b0;
    if (enter_i) begin
      stat_en              = 1'b1;
      stat_d[MODE_W-1:0]   = mode_of(kind_i);
      stat_d[IMASK_B]      = 1'b1;
      if (kind_i == EK_FIQ || kind_i == EK_RESET) stat_d[FMASK_B] = 1'b1;
    end else if (ret_ok_o) begin
      stat_en = 1'b1;
      stat_d  = spsr_o;
    end else if (core_we_i) begin
      stat_en = 1'b1;
      stat_d  = core_wd_i;
    end
  end

  always_comb begin
    bank_we = '0;
    if (enter_i) bank_we[tgt_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= STATUS_RST;
    else if (stat_en) stat_q <= stat_d;
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bank_q[g] <= '0;
      else if (bank_we[g]) bank_q[g] <= stat_q;
    end
  end

  assign status_o = stat_q;

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter logic [WORD_W-1:0] STATUS_RST = 32'h0000_00D3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid_i,
  input  logic [WORD_W-1:0] instr_word_i,
  input  logic [WORD_W-1:0] instr_addr_i,
  input  logic              rst_req_i,
  input  logic              undef_req_i,
  input  logic              pabt_req_i,
  input  logic              dabt_req_i,
  input  logic              irq_req_i,
  input  logic              fiq_req_i,
  input  logic              ret_req_i,
  input  logic [WORD_W-1:0] ret_link_i,
  input  logic              core_we_i,
  input  logic [WORD_W-1:0] core_wd_i,
  output logic [WORD_W-1:0] status_o,
  output logic [WORD_W-1:0] spsr_o,
  output logic              take_o,
  output logic [2:0]        kind_o,
  output logic              pc_load_o,
  output logic [WORD_W-1:0] pc_value_o,
  output logic              link_we_o,
  output logic [WORD_W-1:0] link_value_o,
  output logic              trap_hit_o,
  output logic [NUM_W-1:0]  trap_num_o
);

  // rst_n is expected to arrive already released in step with clk

  exc_kind_e         kind;
  logic              ret_ok;
  logic [WORD_W-1:0] stat;
  logic [WORD_W-1:0] addr_al;
  logic              unused_bits;

  assign unused_bits = ^{instr_word_i[31:28], instr_addr_i[1:0], ret_link_i[1:0]};

  exc_trap_decode u_dec (
    .valid_i (instr_valid_i),
    .word_i  (instr_word_i[27:0]),
    .hit_o   (trap_hit_o),
    .num_o   (trap_num_o)
  );

  exc_arbiter u_arb (
    .boundary_i  (instr_valid_i),
    .imask_i     (stat[IMASK_B]),
    .fmask_i     (stat[FMASK_B]),
    .rst_req_i   (rst_req_i),
    .dabt_req_i  (dabt_req_i),
    .fiq_req_i   (fiq_req_i),
    .irq_req_i   (irq_req_i),
    .pabt_req_i  (pabt_req_i),
    .undef_req_i (undef_req_i),
    .trap_hit_i  (trap_hit_o),
    .kind_o      (kind)
  );

  exc_status_bank #(.STATUS_RST(STATUS_RST)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .enter_i   (take_o),
    .kind_i    (kind),
    .ret_req_i (ret_req_i & instr_valid_i),
    .core_we_i (core_we_i),
    .core_wd_i (core_wd_i),
    .status_o  (stat),
    .spsr_o    (spsr_o),
    .ret_ok_o  (ret_ok)
  );

  always_comb begin
    take_o       = (kind != EK_NONE);
    kind_o       = kind;
    addr_al      = {instr_addr_i[WORD_W-1:2], 2'b00};
    pc_load_o    = take_o | ret_ok;
    pc_value_o   = take_o ? {{(WORD_W-VEC_W){1'b0}}, vec_of(kind)}
                          : {ret_link_i[WORD_W-1:2], 2'b00};
    link_we_o    = take_o && (kind != EK_RESET);
    link_value_o = addr_al + WORD_W'(link_off(kind));
    status_o     = stat;
  end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_valid_i,
  input logic        rst_req_i,
  input logic        core_we_i,
  input logic [31:0] status_o,
  input logic [31:0] spsr_o,
  input logic        take_o,
  input logic [2:0]  kind_o,
  input logic        pc_load_o,
  input logic [31:0] pc_value_o,
  input logic        link_we_o
);

  AST_NO_RESERVED_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (pc_load_o && pc_value_o != 32'h14)); // R1

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |-> (pc_value_o[1:0] == 2'b00)); // R8

  AST_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_valid_i && !rst_req_i) |-> !take_o); // R4

  AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && kind_o == 3'd4) |-> !status_o[7]); // R4

  AST_FIQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && kind_o == 3'd3) |-> !status_o[6]); // R4

  AST_SAVE_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (spsr_o == $past(status_o))); // R5

  AST_TRAP_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && kind_o == 3'd7) |=> (status_o[4:0] == 5'h13 && status_o[7])); // R6

  AST_RESET_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && kind_o == 3'd1) |-> !link_we_o); // R7

  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load_o && !take_o) |=> (status_o == $past(spsr_o))); // R8

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_load_o && !core_we_i) |=> $stable(status_o)); // R11

endmodule

bind exc_entry_unit exc_entry_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .instr_valid_i (instr_valid_i),
  .rst_req_i     (rst_req_i),
  .core_we_i     (core_we_i),
  .status_o      (status_o),
  .spsr_o        (spsr_o),
  .take_o        (take_o),
  .kind_o        (kind_o),
  .pc_load_o     (pc_load_o),
  .pc_value_o    (pc_value_o),
  .link_we_o     (link_we_o)
);

// File: tb/tb_exc_entry_unit.sv
module tb_exc_entry_unit;

  localparam int CLK_P = 10;
  localparam logic [31:0] TRAP_W = 32'hEF00_0011;
  localparam logic [31:0] ALU_W  = 32'hE080_0001;
  localparam logic [31:0] BASE_A = 32'h0000_1000;

  typedef struct packed {
    logic [31:0] pre;
    logic [5:0]  req;   // {rst,dabt,fiq,irq,pabt,undef}
    logic [31:0] ins;
    logic [2:0]  kind;
    logic [7:0]  vec;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{32'h10,       6'b000000, TRAP_W, 3'd7, 8'h08},
    '{32'h10,       6'b000001, ALU_W,  3'd6, 8'h04},
    '{32'h10,       6'b000010, ALU_W,  3'd5, 8'h0C},
    '{32'h10,       6'b010000, ALU_W,  3'd2, 8'h10},
    '{32'h10,       6'b000100, ALU_W,  3'd4, 8'h18},
    '{32'h10,       6'b001000, ALU_W,  3'd3, 8'h1C},
    '{32'h90,       6'b000100, ALU_W,  3'd0, 8'h00},
    '{32'h50,       6'b001000, ALU_W,  3'd0, 8'h00},
    '{32'h90,       6'b001100, ALU_W,  3'd3, 8'h1C},
    '{32'h10,       6'b001100, ALU_W,  3'd3, 8'h1C},
    '{32'h10,       6'b011110, ALU_W,  3'd2, 8'h10},
    '{32'h10,       6'b110000, ALU_W,  3'd1, 8'h00},
    '{32'h10,       6'b000100, TRAP_W, 3'd4, 8'h18},
    '{32'h10,       6'b000010, TRAP_W, 3'd5, 8'h0C},
    '{32'hD0,       6'b001100, TRAP_W, 3'd7, 8'h08},
    '{32'h10,       6'b000000, ALU_W,  3'd0, 8'h00},
    '{32'hA0000010, 6'b000000, TRAP_W, 3'd7, 8'h08}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid_i;
  logic [31:0] instr_word_i, instr_addr_i, ret_link_i, core_wd_i;
  logic        rst_req_i, undef_req_i, pabt_req_i, dabt_req_i;
  logic        irq_req_i, fiq_req_i, ret_req_i, core_we_i;
  logic [31:0] status_o, spsr_o, pc_value_o, link_value_o;
  logic        take_o, pc_load_o, link_we_o, trap_hit_o;
  logic [2:0]  kind_o;
  logic [23:0] trap_num_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_P / 2) clk = ~clk;

  exc_entry_unit dut (
    .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid_i),
    .instr_word_i(instr_word_i), .instr_addr_i(instr_addr_i),
    .rst_req_i(rst_req_i), .undef_req_i(undef_req_i), .pabt_req_i(pabt_req_i),
    .dabt_req_i(dabt_req_i), .irq_req_i(irq_req_i), .fiq_req_i(fiq_req_i),
    .ret_req_i(ret_req_i), .ret_link_i(ret_link_i), .core_we_i(core_we_i),
    .core_wd_i(core_wd_i), .status_o(status_o), .spsr_o(spsr_o),
    .take_o(take_o), .kind_o(kind_o), .pc_load_o(pc_load_o),
    .pc_value_o(pc_value_o), .link_we_o(link_we_o), .link_value_o(link_value_o),
    .trap_hit_o(trap_hit_o), .trap_num_o(trap_num_o)
  );

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    instr_valid_i = 1'b0; instr_word_i = ALU_W; instr_addr_i = BASE_A;
    rst_req_i = 1'b0; undef_req_i = 1'b0; pabt_req_i = 1'b0; dabt_req_i = 1'b0;
    irq_req_i = 1'b0; fiq_req_i = 1'b0; ret_req_i = 1'b0; ret_link_i = '0;
    core_we_i = 1'b0; core_wd_i = '0;
  endtask

  task automatic load_status(input logic [31:0] v);
    @(negedge clk);
    idle();
    core_we_i = 1'b1; core_wd_i = v;
    @(negedge clk);
    idle();
  endtask

  function automatic logic [31:0] exp_stat(input logic [31:0] pre, input logic [2:0] k);
    logic [31:0] r;
    r = pre;
    if (k != 3'd0) begin
      r[7] = 1'b1;
      if (k == 3'd1 || k == 3'd3) r[6] = 1'b1;
      case (k)
        3'd1, 3'd7: r[4:0] = 5'h13;
        3'd2, 3'd5: r[4:0] = 5'h17;
        3'd3:       r[4:0] = 5'h11;
        3'd4:       r[4:0] = 5'h12;
        default:    r[4:0] = 5'h1B;
      endcase
    end
    return r;
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R12 watchdog: act=timeout exp=completion");
    finish_run();
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    cmp("R10 status after reset", status_o, 32'h0000_00D3);
    cmp("R10 saved copy after reset", spsr_o, 32'h0);
    cmp("R11 no pc load in reset", {31'b0, pc_load_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk: priority, masking, vectors, status, saved copy
    for (int i = 0; i < NV; i++) begin
      load_status(TBL[i].pre);
      instr_valid_i = 1'b1;
      instr_word_i  = TBL[i].ins;
      {rst_req_i, dabt_req_i, fiq_req_i, irq_req_i, pabt_req_i, undef_req_i} = TBL[i].req;
      #1;
      cmp($sformatf("R3 kind row %0d", i), {29'b0, kind_o}, {29'b0, TBL[i].kind});
      if (TBL[i].kind != 3'd0) begin
        cmp($sformatf("R1 vector row %0d", i), pc_value_o, {24'b0, TBL[i].vec});
        cmp($sformatf("R12 pc load row %0d", i), {31'b0, pc_load_o}, 32'h1);
        if (TBL[i].kind == 3'd1)
          cmp($sformatf("R7 no link on reset row %0d", i), {31'b0, link_we_o}, 32'h0);
        else
          cmp($sformatf("R7 link row %0d", i), link_value_o,
              BASE_A + ((TBL[i].kind == 3'd2) ? 32'd8 : 32'd4));
      end else begin
        cmp($sformatf("R4 R11 no pc load row %0d", i), {31'b0, pc_load_o}, 32'h0);
      end
      @(negedge clk);
      idle();
      #1;
      cmp($sformatf("R6 R12 status row %0d", i), status_o, exp_stat(TBL[i].pre, TBL[i].kind));
      if (TBL[i].kind != 3'd0)
        cmp($sformatf("R5 saved copy row %0d", i), spsr_o, TBL[i].pre);
    end

    // R2: trap decode, condition field ignored
    @(negedge clk);
    instr_valid_i = 1'b1; instr_word_i = 32'hEF12_3456;
    #1;
    cmp("R2 trap hit", {31'b0, trap_hit_o}, 32'h1);
    cmp("R2 trap number", {8'b0, trap_num_o}, 32'h0012_3456);
    instr_word_i = 32'h0FAB_CDEF;
    #1;
    cmp("R2 trap number other cond", {8'b0, trap_num_o}, 32'h00AB_CDEF);
    instr_word_i = 32'hE3A0_0016;
    #1;
    cmp("R2 non-trap", {31'b0, trap_hit_o}, 32'h0);

    // R7 / R8: trap at unaligned address, then return with unaligned link
    load_status(32'h10);
    instr_valid_i = 1'b1; instr_word_i = 32'hEF00_0100; instr_addr_i = 32'h0000_8106;
    #1;
    cmp("R7 link from unaligned addr", link_value_o, 32'h0000_8108);
    @(negedge clk);
    idle();
    instr_valid_i = 1'b1; ret_req_i = 1'b1; ret_link_i = 32'h0000_810B;
    #1;
    cmp("R8 return pc load", {31'b0, pc_load_o}, 32'h1);
    cmp("R8 return pc value", pc_value_o, 32'h0000_8108);
    cmp("R8 return not an entry", {31'b0, take_o}, 32'h0);
    @(negedge clk);
    idle();
    #1;
    cmp("R8 status restored", status_o, 32'h10);

    // R9: return in user mode ignored
    @(negedge clk);
    instr_valid_i = 1'b1; ret_req_i = 1'b1; ret_link_i = 32'h0000_4000;
    #1;
    cmp("R9 no pc load in user mode", {31'b0, pc_load_o}, 32'h0);
    @(negedge clk);
    idle();
    #1;
    cmp("R9 status unchanged", status_o, 32'h10);

    // R8: entry wins over return in the same cycle
    load_status(32'h13);
    instr_valid_i = 1'b1; ret_req_i = 1'b1; irq_req_i = 1'b1; ret_link_i = 32'h0000_4000;
    #1;
    cmp("R8 entry over return pc", pc_value_o, 32'h18);
    @(negedge clk);
    idle();
    #1;
    cmp("R8 entry over return status", status_o, 32'h92);

    // R4: off boundary, interrupt waits but reset is taken
    load_status(32'h10);
    irq_req_i = 1'b1;
    #1;
    cmp("R4 irq off boundary", {31'b0, take_o}, 32'h0);
    @(negedge clk);
    #1;
    cmp("R4 status kept off boundary", status_o, 32'h10);
    idle();
    rst_req_i = 1'b1;
    #1;
    cmp("R4 reset off boundary", {29'b0, kind_o}, 32'h1);
    @(negedge clk);
    idle();
    #1;
    cmp("R4 reset status", status_o, 32'hD3);

    // R11: core write colliding with an entry is ignored
    load_status(32'h10);
    instr_valid_i = 1'b1; instr_word_i = TRAP_W; core_we_i = 1'b1; core_wd_i = 32'h1F;
    @(negedge clk);
    idle();
    #1;
    cmp("R11 core write loses to entry", status_o, 32'h93);

    finish_run();
  end

endmodule